// File: doc/BRIEF.md
# Prioritized Restart Interrupt Controller

This block sits next to a processor core and decides which of five interrupt requests is handed to the core, and where the core should go next. The five sources are a non-maskable trap, three maskable restart lines ranked 7.5, 6.5 and 5.5, and one general request. The block qualifies each source by its own sensing rule. It applies the global enable flag and the three mask bits, and picks the highest-ranked source that survives. It then presents a request strobe with either a fixed restart address or, for the general request, a flag saying that the vector must come from outside.

The core talks back through three inputs. A service acknowledge clears the source that was served and drops the enable flag. An enable strobe sets the flag again. A set-mask write updates the mask bits and can discard a latched 7.5 request. A read port reports the masks, the enable flag and the raw pending state of the three restart lines. Stacking the return address, and the bus cycles that fetch an external vector, belong to the core.

Top module: `irq_restart_ctrl`

## Requirements
- R1: After reset all three mask bits are 1, the enable flag is 0, the 7.5 latch and the trap filter are clear, `irq_req` is 0 and `rd_status` reads 7'h07.
- R2: Fixed ranking, highest first: trap, 7.5, 6.5, 5.5, general. The address in `irq_vec` is 16'h0024 for trap, 16'h003C for 7.5, 16'h0034 for 6.5 and 16'h002C for 5.5. For the general request `irq_ext` is 1 and `irq_vec` is 0. `irq_src` encodes none=0, trap=1, 7.5=2, 6.5=3, 5.5=4, general=5.
- R3: A restart source is granted only while the enable flag is 1 and its mask bit is 0. The general source needs only the enable flag.
- R4: The trap is granted regardless of the enable flag and the masks.
- R5: The 5.5, 6.5 and general inputs are level-sensitive. Their requests follow the input within the same cycle and vanish when it drops.
- R6: A rising edge on `rq75_in` sets the 7.5 latch on that clock edge, even while 7.5 is masked or the enable flag is 0.
- R7: The 7.5 latch is cleared by an acknowledge that serves 7.5, or by a mask write with bit 4 set. A new rising edge in the same cycle wins over the clear.
- R8: A mask write (`mw_valid`) loads `mw_data[2:0]` into the masks for 5.5, 6.5 and 7.5 (bit 0 to bit 2) only when `mw_data[3]` is 1. Otherwise the masks keep their value.
- R9: The trap is recognized after `trap_in` rises and only while it stays high. If it drops before acknowledge, the request is cancelled. After an acknowledge it is not granted again until the input goes low and then high.
- R10: An acknowledge while `irq_req` is 1 clears the enable flag, whatever source was served. `ei` sets the flag, and an acknowledge in the same cycle wins. An acknowledge while `irq_req` is 0 changes nothing.
- R11: `rd_status` reads {7.5 latch, `rq65_in`, `rq55_in`, enable, mask 7.5, mask 6.5, mask 5.5} from bit 6 down to bit 0, regardless of masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_in | input | 1 | Non-maskable trap request |
| rq75_in | input | 1 | Edge-latched restart request, highest maskable rank |
| rq65_in | input | 1 | Level restart request, middle rank |
| rq55_in | input | 1 | Level restart request, lowest restart rank |
| gen_in | input | 1 | Level general request, lowest rank |
| ack | input | 1 | Service acknowledge for the presented request |
| ei | input | 1 | Enable-instruction strobe |
| mw_valid | input | 1 | Set-mask write strobe |
| mw_data | input | 5 | Write data: [2:0] masks, [3] mask load enable, [4] clear 7.5 latch |
| irq_req | output | 1 | A granted request is presented |
| irq_src | output | 3 | Encoded granted source |
| irq_vec | output | 16 | Restart address of the granted source |
| irq_ext | output | 1 | Granted source needs an external vector |
| rd_status | output | 7 | Masks, enable flag and restart pending state |

## Verification
A lost or stuck 7.5 latch shows on bit 6 of `rd_status` one edge after the pulse, even while that source is masked, so the bench can see it without a grant. A wrong enable flag or mask shows in `rd_status` and in `irq_req` in the cycle right after the write, acknowledge or enable strobe. A trap filter that re-arms too early presents `irq_req` with address 0x0024 on the edge after an acknowledge while the trap input is still high. Ranking faults show in the same cycle as a change of the level inputs, because the grant path has no register.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_GEN  = 3'd5
  } irq_src_e;

  localparam int NUM_RST = 3;
  localparam int MW_W    = NUM_RST + 2;

  // Restart slot number for each source: the address is slot*8 + 4.
  function automatic logic [3:0] slot_of(irq_src_e s);
    case (s)
      SRC_TRAP: slot_of = 4'd4;
      SRC_R55:  slot_of = 4'd5;
      SRC_R65:  slot_of = 4'd6;
      SRC_R75:  slot_of = 4'd7;
      default:  slot_of = 4'd0;
    endcase
  endfunction

  function automatic logic [15:0] vec_of(irq_src_e s);
    logic [3:0] sl;
    sl = slot_of(s);
    if (sl == 4'd0) vec_of = 16'h0000;
    else            vec_of = {9'd0, sl, 3'b100};
  endfunction

endpackage

// File: rtl/irq_trap_filter.sv
module irq_trap_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_in,
  input  logic served,
  output logic trap_req
);
  logic trap_d;
  logic armed;
  logic rise;

  assign rise     = trap_in & ~trap_d;
  assign trap_req = armed & trap_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_d <= 1'b0;
      armed  <= 1'b0;
    end else begin
      trap_d <= trap_in;
      if (served || !trap_in) armed <= 1'b0;
      else if (rise)          armed <= 1'b1;
    end
  end

  assert_trap_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    served |=> !trap_req);
  assert_trap_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> trap_in);
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_in,
  input  logic clr,
  output logic hit
);
  logic lvl_d;
  logic rise;

  assign rise = lvl_in & ~lvl_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      hit   <= 1'b0;
    end else begin
      lvl_d <= lvl_in;
      if (rise)     hit <= 1'b1;
      else if (clr) hit <= 1'b0;
    end
  end

  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> hit);
  assert_edge_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !rise) |=> !hit);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             q_trap,
  input  logic             q_r75,
  input  logic             q_r65,
  input  logic             q_r55,
  input  logic             q_gen,
  output irq_src_e         src,
  output logic [VEC_W-1:0] vec,
  output logic             ext
);
  localparam int NSRC = 5;
  logic [NSRC-1:0] reqs;
  irq_src_e        order [NSRC];

  assign reqs = {q_gen, q_r55, q_r65, q_r75, q_trap};

  always_comb begin
    order[0] = SRC_TRAP;
    order[1] = SRC_R75;
    order[2] = SRC_R65;
    order[3] = SRC_R55;
    order[4] = SRC_GEN;
  end

  always_comb begin
    src = SRC_NONE;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (reqs[i]) src = order[i];
    end
  end

  logic [15:0] full_vec;
  assign full_vec = vec_of(src);
  assign vec      = full_vec[VEC_W-1:0];
  assign ext      = (src == SRC_GEN);
endmodule

// File: rtl/irq_restart_ctrl.sv
module irq_restart_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trap_in,
  input  logic             rq75_in,
  input  logic             rq65_in,
  input  logic             rq55_in,
  input  logic             gen_in,
  input  logic             ack,
  input  logic             ei,
  input  logic             mw_valid,
  input  logic [4:0]       mw_data,
  output logic             irq_req,
  output logic [2:0]       irq_src,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_ext,
  output logic [6:0]       rd_status
);
  localparam int MSK_LD  = NUM_RST;
  localparam int CLR_75  = NUM_RST + 1;

  logic [NUM_RST-1:0] mask_q;
  logic               en_q;
  logic               l75;
  logic               trap_req;
  irq_src_e           grant;

  // Named internal events for checking.
  logic take;
  logic mask_load;
  logic clr75_wr;
  logic served_trap;
  logic served_75;
  logic q_r75, q_r65, q_r55, q_gen;

  assign take        = ack & (grant != SRC_NONE);
  assign mask_load   = mw_valid & mw_data[MSK_LD];
  assign clr75_wr    = mw_valid & mw_data[CLR_75];
  assign served_trap = take & (grant == SRC_TRAP);
  assign served_75   = take & (grant == SRC_R75);

  assign q_r75 = en_q & ~mask_q[2] & l75;
  assign q_r65 = en_q & ~mask_q[1] & rq65_in;
  assign q_r55 = en_q & ~mask_q[0] & rq55_in;
  assign q_gen = en_q & gen_in;

  irq_trap_filter u_trap (
    .clk      (clk),
    .rst_n    (rst_n),
    .trap_in  (trap_in),
    .served   (served_trap),
    .trap_req (trap_req)
  );

  irq_edge_latch u_l75 (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_in (rq75_in),
    .clr    (served_75 | clr75_wr),
    .hit    (l75)
  );

  irq_prio_sel #(.VEC_W(VEC_W)) u_sel (
    .q_trap (trap_req),
    .q_r75  (q_r75),
    .q_r65  (q_r65),
    .q_r55  (q_r55),
    .q_gen  (q_gen),
    .src    (grant),
    .vec    (irq_vec),
    .ext    (irq_ext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      en_q   <= 1'b0;
    end else begin
      if (mask_load) mask_q <= mw_data[NUM_RST-1:0];
      if (take)      en_q   <= 1'b0;
      else if (ei)   en_q   <= 1'b1;
    end
  end

  assign irq_req   = (grant != SRC_NONE);
  assign irq_src   = grant;
  assign rd_status = {l75, rq65_in, rq55_in, en_q, mask_q};

  assert_mask_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_load |=> $stable(mask_q));
  assert_en_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !en_q);
  assert_trap_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> (irq_src == SRC_TRAP));
  assert_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_src != SRC_TRAP) |-> en_q);
  assert_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src == SRC_R65) |-> rq65_in);
  assert_rank_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src == SRC_R55) |-> (!l75 || mask_q[2]));
endmodule

// File: tb/irq_restart_ctrl_bench.sv
`timescale 1ns/1ps
module irq_restart_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trap_in = 0, rq75_in = 0, rq65_in = 0, rq55_in = 0, gen_in = 0;
  logic       ack = 0, ei = 0, mw_valid = 0;
  logic [4:0] mw_data = 0;
  logic       irq_req;
  logic [2:0] irq_src;
  logic [15:0] irq_vec;
  logic       irq_ext;
  logic [6:0] rd_status;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_restart_ctrl u_irq_restart_ctrl (
    .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .rq75_in(rq75_in),
    .rq65_in(rq65_in), .rq55_in(rq55_in), .gen_in(gen_in), .ack(ack),
    .ei(ei), .mw_valid(mw_valid), .mw_data(mw_data), .irq_req(irq_req),
    .irq_src(irq_src), .irq_vec(irq_vec), .irq_ext(irq_ext),
    .rd_status(rd_status)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic wr_mask(input logic [4:0] v);
    mw_valid = 1; mw_data = v;
    cyc();
    mw_valid = 0; mw_data = 0;
  endtask

  task automatic do_ei();
    ei = 1; cyc(); ei = 0;
  endtask

  task automatic do_ack();
    ack = 1; cyc(); ack = 0;
  endtask

  task automatic grant_is(input string tag, input logic [2:0] s, input logic [15:0] v, input logic x);
    chk({tag, " req"}, irq_req, s != 0);
    chk({tag, " src"}, irq_src, s);
    chk({tag, " vec"}, irq_vec, v);
    chk({tag, " ext"}, irq_ext, x);
  endtask

  task automatic t_reset();
    chk("R1 status", rd_status, 7'h07);
    chk("R1 req", irq_req, 0);
  endtask

  task automatic t_priority();
    wr_mask(5'b01000);
    do_ei();
    chk("R11 enabled unmasked", rd_status, 7'b0001000);
    rq55_in = 1; settle();
    grant_is("R2 r55", 3'd4, 16'h002C, 0);
    rq65_in = 1; settle();
    grant_is("R2 r65", 3'd3, 16'h0034, 0);
    rq75_in = 1; cyc();
    grant_is("R2 r75", 3'd2, 16'h003C, 0);
    trap_in = 1; cyc();
    grant_is("R2 trap", 3'd1, 16'h0024, 0);
    trap_in = 0; settle();
    grant_is("R9 trap drop", 3'd2, 16'h003C, 0);
    do_ack();
    chk("R7 ack clears latch", rd_status[6], 0);
    chk("R10 ack drops enable", rd_status[3], 0);
    chk("R3 blocked when disabled", irq_req, 0);
    do_ei();
    grant_is("R2 r65 after ei", 3'd3, 16'h0034, 0);
    rq65_in = 0; settle();
    grant_is("R5 r65 drop", 3'd4, 16'h002C, 0);
    rq55_in = 0; settle();
    chk("R5 r55 drop", irq_req, 0);
    gen_in = 1; settle();
    grant_is("R2 general", 3'd5, 16'h0000, 1);
    gen_in = 0; rq75_in = 0; cyc();
  endtask

  task automatic t_mask();
    wr_mask(5'b00111);
    chk("R8 no load without bit3", rd_status[2:0], 3'b000);
    wr_mask(5'b01001);
    chk("R8 load", rd_status[2:0], 3'b001);
    rq55_in = 1; settle();
    chk("R3 masked r55", irq_req, 0);
    chk("R11 raw r55 pending", rd_status[4], 1);
    rq65_in = 1; settle();
    grant_is("R3 unmasked r65", 3'd3, 16'h0034, 0);
    rq55_in = 0; rq65_in = 0; cyc();
  endtask

  task automatic t_latch();
    wr_mask(5'b01100);
    rq75_in = 1; cyc(); rq75_in = 0; cyc();
    chk("R6 latched while masked", rd_status[6], 1);
    chk("R3 masked r75", irq_req, 0);
    wr_mask(5'b10000);
    chk("R7 write clears latch", rd_status[6], 0);
    chk("R8 clear keeps masks", rd_status[2:0], 3'b100);
    rq75_in = 1; cyc(); rq75_in = 0;
    wr_mask(5'b01000);
    grant_is("R6 unmask latched r75", 3'd2, 16'h003C, 0);
    cyc();
    rq75_in = 1; mw_valid = 1; mw_data = 5'b10000; cyc();
    mw_valid = 0; mw_data = 0; rq75_in = 0;
    chk("R7 edge wins over clear", rd_status[6], 1);
    do_ack();
    chk("R7 ack clears", rd_status[6], 0);
    chk("R10 enable off", rd_status[3], 0);
  endtask

  task automatic t_trap();
    wr_mask(5'b01111);
    trap_in = 1; settle();
    chk("R9 not before edge", irq_req, 0);
    cyc();
    grant_is("R4 trap disabled+masked", 3'd1, 16'h0024, 0);
    trap_in = 0; cyc();
    trap_in = 1; settle();
    chk("R9 cancelled", irq_req, 0);
    cyc();
    chk("R9 new rise", irq_req, 1);
    do_ack();
    chk("R9 held high not regranted", irq_req, 0);
    cyc(); cyc();
    chk("R9 still not regranted", irq_req, 0);
    trap_in = 0; cyc();
    trap_in = 1; cyc();
    grant_is("R9 rearmed", 3'd1, 16'h0024, 0);
    do_ack(); trap_in = 0; cyc();
  endtask

  task automatic t_ack_rules();
    wr_mask(5'b01000);
    do_ei();
    rq55_in = 1;
    ack = 1; ei = 1; cyc(); ack = 0; ei = 0;
    chk("R10 ack beats ei", rd_status[3], 0);
    rq55_in = 0;
    do_ei();
    do_ack();
    chk("R10 idle ack ignored", rd_status[3], 1);
  endtask

  initial begin
    #800000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    cyc(); cyc();
    rst_n = 1;
    cyc();
    t_reset();
    t_priority();
    t_mask();
    t_latch();
    t_trap();
    t_ack_rules();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule